// File: doc/BRIEF.md
# While-less-than loop predicate generator

This block turns the scalar state of a counted loop into a lane mask for a vector datapath whose width is set by a parameter. Each request supplies a signed 64-bit induction value, a signed 64-bit bound and an element size: byte, halfword, word or doubleword. The block returns a predicate with one bit per byte of the vector. In that predicate, element lane `j` is active when `induction + j < bound`. Loop code can then run the tail iterations under the mask, so no separate scalar tail loop is needed.

A lane of an element wider than a byte spans 2, 4 or 8 predicate bits. Only the lowest bit of each lane carries the result, and the other bits of that lane are written as zero. Lane order runs from bit 0 (the first lane) to the top of the vector (the last lane). From the registered predicate the block derives four summary flags: first, any, none and last. It also gives the number of elements per vector for the selected size, so the caller can step the induction value by that amount. All results are registered and appear one cycle after the request, together with a valid strobe.

Top module: `loop_pred_gen`

## Requirements
- R1: For element size code 0/1/2/3 (8/16/32/64-bit elements), lane `j` (`0 <= j < VEC_BITS/elem_bits`) is active exactly when the signed sum `induct + j` is less than the signed `bound`. Lane `j` of size code `s` occupies predicate bits `[j*2^s +: 2^s]`.
- R2: In every generated predicate, only the least significant bit of each lane can be 1. All other bits of the lane are 0.
- R3: The active lanes always form a contiguous run that starts at lane 0. Example: with a 256-bit vector, 32-bit elements, induction 0 and bound 7, the predicate is 0x01111111.
- R4: `flag_first` is the state of lane 0. `flag_last` is the state of the highest lane of the selected size. `flag_any` is set when any lane is active, and `flag_none` is its complement.
- R5: `elem_count` equals `VEC_BITS` divided by the element width of the captured size (32, 16, 8 or 4 for a 256-bit vector).
- R6: A request taken with `in_valid` high produces `out_valid` high on the next cycle, with the predicate, flags and count for that request. `out_valid` is low in a cycle after a cycle without a request.
- R7: The sum `induct + j` is formed without wraparound. A lane whose sum would exceed the largest signed 64-bit value is inactive. For example, induction 2^63-3 with bound 2^63-1 gives exactly two active lanes.
- R8: While `in_valid` is low, the predicate, flags and count keep their last values, whatever happens on the other inputs.
- R9: After a synchronous active-low reset: `out_valid`=0, the predicate is all zero, `flag_none`=1, the other flags are 0, and `elem_count` shows the byte count (`VEC_BITS/8`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| induct | input | 64 | Signed induction value |
| bound | input | 64 | Signed loop bound |
| esize | input | 2 | Element size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| pred | output | VEC_BITS/8 | Byte-granular predicate |
| flag_first | output | 1 | Lane 0 active |
| flag_any | output | 1 | At least one lane active |
| flag_none | output | 1 | No lane active |
| flag_last | output | 1 | Highest lane active |
| elem_count | output | $clog2(VEC_BITS/8)+1 | Elements per vector for the captured size |

## Verification
The bench builds the block with its default 256-bit vector, giving a 32-bit predicate. At that width all four element sizes have distinct lane counts (32, 16, 8 and 4), so the check of "last lane" and the full-vector case are reached for every size. Induction and bound values are drawn near each other, so partial masks appear often. Directed cases at the extreme signed values cover negative operands and the overflow corner, where a wrapping adder would wrongly activate lanes.

// File: rtl/loop_pred_pkg.sv
// Shared types for the loop predicate generator.
// Assumes element sizes are powers of two from one to eight bytes.
package loop_pred_pkg;
    typedef enum logic [1:0] {
        ES_BYTE  = 2'd0,
        ES_HALF  = 2'd1,
        ES_WORD  = 2'd2,
        ES_DWORD = 2'd3
    } esize_e;
endpackage

// File: rtl/lane_compare.sv
// Per-index signed "below bound" test: below[k] = (induct + k < bound).
// The sum is widened by one bit, so it never wraps.
// Index k serves lane k of every element size.
module lane_compare #(
    parameter int DATA_W = 64,
    parameter int LANES  = 32
) (
    input  logic [DATA_W-1:0] induct,
    input  logic [DATA_W-1:0] bound,
    output logic [LANES-1:0]  below
);
    localparam int EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0] induct_x;
    logic signed [EXT_W-1:0] bound_x;

    // Sign-extend both operands by one bit.
    assign induct_x = $signed({induct[DATA_W-1], induct});
    assign bound_x  = $signed({bound[DATA_W-1], bound});

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [EXT_W-1:0] sum;
        // Offset the induction by the lane index, then compare.
        assign sum      = induct_x + $signed(EXT_W'(k));
        assign below[k] = (sum < bound_x);
    end
endmodule

// File: rtl/pred_expand.sv
// Places lane results onto the byte-granular predicate for the selected size.
// Only the lowest bit of each lane is driven; the other bits are zero.
// Assumes PRED_BITS is a multiple of 8.
module pred_expand
    import loop_pred_pkg::*;
#(
    parameter int PRED_BITS = 32
) (
    input  logic [PRED_BITS-1:0] below,
    input  esize_e               esize,
    output logic [PRED_BITS-1:0] pred
);
    logic [PRED_BITS-1:0] p8, p16, p32, p64;

    for (genvar b = 0; b < PRED_BITS; b++) begin : g_bit
        assign p8[b] = below[b];
        if (b % 2 == 0) begin : g_h
            assign p16[b] = below[b/2];
        end else begin : g_hz
            assign p16[b] = 1'b0;
        end
        if (b % 4 == 0) begin : g_w
            assign p32[b] = below[b/4];
        end else begin : g_wz
            assign p32[b] = 1'b0;
        end
        if (b % 8 == 0) begin : g_d
            assign p64[b] = below[b/8];
        end else begin : g_dz
            assign p64[b] = 1'b0;
        end
    end

    // Pick the layout for the requested element size.
    always_comb begin
        unique case (esize)
            ES_BYTE:  pred = p8;
            ES_HALF:  pred = p16;
            ES_WORD:  pred = p32;
            default:  pred = p64;
        endcase
    end
endmodule

// File: rtl/pred_flags.sv
// Summary flags of a predicate in lane order (bit 0 is the first lane).
// Assumes only the lowest bit of each lane can be set.
module pred_flags
    import loop_pred_pkg::*;
#(
    parameter int PRED_BITS = 32
) (
    input  logic [PRED_BITS-1:0] pred,
    input  esize_e               esize,
    output logic                 first,
    output logic                 any,
    output logic                 none,
    output logic                 last
);
    // First lane and any-lane summary.
    always_comb begin
        first = pred[0];
        any   = |pred;
        none  = ~any;
    end

    // The lowest bit of the highest lane depends on the element size.
    always_comb begin
        unique case (esize)
            ES_BYTE:  last = pred[PRED_BITS-1];
            ES_HALF:  last = pred[PRED_BITS-2];
            ES_WORD:  last = pred[PRED_BITS-4];
            default:  last = pred[PRED_BITS-8];
        endcase
    end
endmodule

// File: rtl/loop_pred_gen.sv
// While-less-than loop predicate generator.
// Captures a request, registers the predicate and size, and derives flags
// and the element count from the registered state (one-cycle latency).
// Assumes VEC_BITS is a multiple of 64.
module loop_pred_gen
    import loop_pred_pkg::*;
#(
    parameter int VEC_BITS = 256,
    parameter int DATA_W   = 64,
    localparam int PRED_BITS = VEC_BITS / 8,
    localparam int CNT_W     = $clog2(PRED_BITS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    induct,
    input  logic [DATA_W-1:0]    bound,
    input  logic [1:0]           esize,
    output logic                 out_valid,
    output logic [PRED_BITS-1:0] pred,
    output logic                 flag_first,
    output logic                 flag_any,
    output logic                 flag_none,
    output logic                 flag_last,
    output logic [CNT_W-1:0]     elem_count
);
    esize_e               size_in;
    esize_e               size_q;
    logic [PRED_BITS-1:0] below;
    logic [PRED_BITS-1:0] pred_next;
    logic [PRED_BITS-1:0] pred_q;

    assign size_in = esize_e'(esize);

    lane_compare #(.DATA_W(DATA_W), .LANES(PRED_BITS)) u_cmp (
        .induct (induct),
        .bound  (bound),
        .below  (below)
    );

    pred_expand #(.PRED_BITS(PRED_BITS)) u_exp (
        .below (below),
        .esize (size_in),
        .pred  (pred_next)
    );

    // Capture the predicate and size on a request; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pred_q    <= '0;
            size_q    <= ES_BYTE;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                pred_q <= pred_next;
                size_q <= size_in;
            end
        end
    end

    assign pred = pred_q;

    pred_flags #(.PRED_BITS(PRED_BITS)) u_flags (
        .pred  (pred_q),
        .esize (size_q),
        .first (flag_first),
        .any   (flag_any),
        .none  (flag_none),
        .last  (flag_last)
    );

    // Elements per vector for the captured size.
    assign elem_count = CNT_W'(PRED_BITS >> size_q);

    // Mask of the bits that may be set for a given size.
    function automatic logic [PRED_BITS-1:0] lane_lsb_mask(input esize_e s);
        logic [PRED_BITS-1:0] m;
        m = '0;
        for (int b = 0; b < PRED_BITS; b++) begin
            if ((b % (1 << s)) == 0) m[b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

    p_lane_lsb_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((pred & ~lane_lsb_mask(size_q)) == '0));

    p_prefix_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_any |-> flag_first);

    p_last_needs_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_last |-> flag_first);

    p_full_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_last) |-> ($countones(pred) == int'(elem_count)));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> out_valid);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(induct) == MAX_POS) |-> (pred == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(pred) && $stable(elem_count)));
endmodule

// File: tb/loop_pred_gen_test.sv
module loop_pred_gen_test;
    localparam int VB = 256;
    localparam int PB = VB / 8;
    localparam int CW = $clog2(PB) + 1;
    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [63:0]   induct = '0;
    logic [63:0]   bound = '0;
    logic [1:0]    esize = '0;
    logic          out_valid;
    logic [PB-1:0] pred;
    logic          flag_first, flag_any, flag_none, flag_last;
    logic [CW-1:0] elem_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    loop_pred_gen #(.VEC_BITS(VB)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .induct(induct), .bound(bound), .esize(esize),
        .out_valid(out_valid), .pred(pred),
        .flag_first(flag_first), .flag_any(flag_any),
        .flag_none(flag_none), .flag_last(flag_last),
        .elem_count(elem_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Active-lane count from the distance between bound and induction.
    function automatic int exp_n(input logic [63:0] i, input logic [63:0] b, input int s);
        logic signed [64:0] d;
        int nl;
        nl = PB >> s;
        d = $signed({b[63], b}) - $signed({i[63], i});
        if (d <= 0) return 0;
        if (d >= 65'(nl)) return nl;
        return int'(d);
    endfunction

    function automatic logic [PB-1:0] exp_pred(input int n, input int s);
        logic [PB-1:0] p;
        p = '0;
        for (int j = 0; j < n; j++) p[j << s] = 1'b1;
        return p;
    endfunction

    // Issue one request and check the registered result one cycle later.
    task automatic run(input string tag, input logic [63:0] i, input logic [63:0] b, input int s);
        int n;
        int nl;
        n = exp_n(i, b, s);
        nl = PB >> s;
        @(negedge clk);
        induct = i; bound = b; esize = 2'(s); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R6 valid"}, 64'(out_valid), 64'd1);
        chk({tag, " R1/R2/R3 pred"}, 64'(pred), 64'(exp_pred(n, s)));
        chk({tag, " R4 first"}, 64'(flag_first), 64'(n > 0));
        chk({tag, " R4 any"}, 64'(flag_any), 64'(n > 0));
        chk({tag, " R4 none"}, 64'(flag_none), 64'(n == 0));
        chk({tag, " R4 last"}, 64'(flag_last), 64'(n == nl));
        chk({tag, " R5 count"}, 64'(elem_count), 64'(nl));
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [PB-1:0] held;
        logic [CW-1:0] held_cnt;
        void'($urandom(32'd20240611));
        in_valid = 1'b1;
        induct = 64'd0;
        bound = 64'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        // Reset state, sampled before any request.
        chk("R9 valid", 64'(out_valid), 64'd0);
        chk("R9 pred", 64'(pred), 64'd0);
        chk("R9 none", 64'(flag_none), 64'd1);
        chk("R9 any", 64'(flag_any), 64'd0);
        chk("R9 count", 64'(elem_count), 64'(PB));

        // R3 worked example: 32-bit lanes, bound 7.
        run("R3 example", 64'd0, 64'd7, 2);
        chk("R3 example literal", 64'(pred), 64'h0111_1111);
        run("R1 empty byte", 64'd9, 64'd9, 0);
        run("R1 full dword", 64'd0, 64'd100, 3);
        run("R1 negative half", 64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFE, 1);
        run("R1 min to max", MINN, MAXP, 0);
        run("R1 bound below", 64'd3, 64'hFFFF_FFFF_FFFF_FFF0, 2);
        run("R7 near max", MAXP - 64'd2, MAXP, 0);
        chk("R7 literal", 64'(pred), 64'h3);
        run("R7 at max", MAXP, MAXP, 3);

        // R6: no new request gives no strobe.
        @(negedge clk);
        chk("R6 idle valid", 64'(out_valid), 64'd0);

        // R8: inputs change while in_valid is low; outputs hold.
        held = pred;
        held_cnt = elem_count;
        induct = 64'd0; bound = 64'd1000; esize = 2'd0;
        repeat (2) @(negedge clk);
        chk("R8 hold pred", 64'(pred), 64'(held));
        chk("R8 hold count", 64'(elem_count), 64'(held_cnt));

        // Random pairs with the bound close to the induction value.
        for (int t = 0; t < 400; t++) begin
            logic [63:0] b;
            logic [63:0] i;
            int s;
            b = {$urandom, $urandom};
            i = b - 64'($urandom_range(40)) + 64'd6;
            s = int'($urandom_range(3));
            run("R1 random", i, b, s);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule